// File: doc/BRIEF.md
# Hardware Semaphore Register Bank

This block gives several bus masters a shared set of lock registers with no read-modify-write bus lock. Each lock register holds an 8-bit owner ID, and the value 0 means free. A master takes a lock by writing its own nonzero ID with an ordinary write. It then reads the register back. If the read returns its ID, the master holds the lock. Releasing a lock is a write of 0.

Each lock register is a two-state machine.

- State SEM_FREE, which holds the value 0:
  - Transition TAKE: a granted nonzero write moves the register to SEM_HELD and stores the written ID.
  - Transition IDLE_ZERO: a granted write of 0 leaves the register in SEM_FREE.
- State SEM_HELD, which holds the owner ID:
  - Transition RELEASE: a granted write of 0 returns the register to SEM_FREE.
  - Transition REJECT: a granted nonzero write is dropped, and the register keeps its owner.

A per-register arbiter grants one write per cycle. When several masters write the same register in the same cycle, the lowest-numbered master wins.

Each master has its own port: write enable, address, write data and read data. Reads are combinational and have no side effects.

Top module: `sem_bank`

## Requirements
- R1: After reset, every lock register reads 0.
- R2: A nonzero write to a register that holds 0 stores the written ID. A read returns that ID from the next cycle on.
- R3: A nonzero write to a register that holds a nonzero value is dropped, and the register keeps its previous owner.
- R4: A master's read data equals the current content of the register its address selects, in the same cycle. Reads change no register.
- R5: A write of 0 from any master clears a held register to 0.
- R6: After a master writes its ID, a read-back by that master returns its ID only if its write was the one applied.
- R7: When several masters write the same register in one cycle, only the write of the lowest-numbered master is applied. The others are dropped, whatever their values.
- R8: A write of 0 to a free register leaves it at 0. Under R7, such a write from a lower-numbered master also blocks a higher-numbered master's take in the same cycle.
- R9: Writes by different masters to different registers in the same cycle are all applied independently.
- R10: For master m, the address occupies bits [m*4 +: 4] of `bus_addr`, and its write data and read data occupy bits [m*8 +: 8] of `bus_wdata` and `bus_rdata`. The address value is the register index, 0 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | NUM_MASTERS | Per-master write enable |
| bus_addr | input | NUM_MASTERS*4 | Per-master register index, packed by master |
| bus_wdata | input | NUM_MASTERS*8 | Per-master write data (owner ID), packed by master |
| bus_rdata | output | NUM_MASTERS*8 | Per-master read data, packed by master |

## Verification
The bench builds the bank with three masters, sixteen registers and 8-bit IDs. Three masters are enough for a three-way collision on one register, and for a collision in which a lower-numbered master's zero write sits between two others. In the random phase, addresses are confined to a few registers for part of the run. This makes same-cycle contention, rejected takes and cross-master releases frequent. A second part spreads accesses over all sixteen registers to exercise independence.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic {
        SEM_FREE = 1'b0,
        SEM_HELD = 1'b1
    } sem_state_e;

endpackage

// File: rtl/sem_arbiter.sv
module sem_arbiter #(
    parameter int NUM_MASTERS = 3,
    parameter int ADDR_W      = 4,
    parameter int ID_W        = 8,
    parameter int SEM_IDX     = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_MASTERS-1:0]        we,
    input  logic [NUM_MASTERS*ADDR_W-1:0] addr,
    input  logic [NUM_MASTERS*ID_W-1:0]   wdata,
    output logic [NUM_MASTERS-1:0]        grant,
    output logic                          wr_valid,
    output logic [ID_W-1:0]               wr_data
);

    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(SEM_IDX);

    logic [NUM_MASTERS-1:0] req;

    always_comb begin
        for (int i = 0; i < NUM_MASTERS; i++) begin
            req[i] = we[i] && (addr[i*ADDR_W +: ADDR_W] == MY_ADDR);
        end
    end

    // Lowest-numbered requester wins: scan downward so the last hit sticks.
    always_comb begin
        grant    = '0;
        wr_valid = 1'b0;
        wr_data  = '0;
        for (int i = NUM_MASTERS - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                wr_valid = 1'b1;
                wr_data  = wdata[i*ID_W +: ID_W];
            end
        end
    end

    // R7: at most one master is granted per register per cycle
    p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R7: a grant only goes to a master that is actually writing this register
    p_grant_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    // R7: any request at all produces exactly one grant
    p_req_served_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> ($countones(grant) == 1));

endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    input  logic [ID_W-1:0] wr_data,
    output logic [ID_W-1:0] owner
);

    sem_state_e      state_q, state_d;
    logic [ID_W-1:0] owner_q, owner_d;

    // Next-state and next-owner decision
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            SEM_FREE: begin
                if (wr_valid && (wr_data != '0)) begin     // TAKE
                    state_d = SEM_HELD;
                    owner_d = wr_data;
                end                                          // IDLE_ZERO otherwise
            end
            SEM_HELD: begin
                if (wr_valid && (wr_data == '0)) begin     // RELEASE
                    state_d = SEM_FREE;
                    owner_d = '0;
                end                                          // REJECT otherwise
            end
            default: begin
                state_d = SEM_FREE;
                owner_d = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEM_FREE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    // Output
    always_comb begin
        owner = owner_q;
    end

    // R1: the state and the stored ID agree (free means zero)
    p_state_owner_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_FREE) == (owner_q == '0));

    // R2: a nonzero write to a free register stores that ID
    p_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_FREE && wr_valid && wr_data != '0)
        |=> (owner_q == $past(wr_data)));

    // R3: a held register keeps its owner unless a zero write arrives
    p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_HELD && !(wr_valid && wr_data == '0))
        |=> $stable(owner_q));

    // R5: a zero write always leaves the register free
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_data == '0) |=> (state_q == SEM_FREE));

endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
    parameter int NUM_SEMS = 16,
    parameter int ADDR_W   = 4,
    parameter int ID_W     = 8
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NUM_SEMS*ID_W-1:0] owners,
    output logic [ID_W-1:0]          rdata
);

    // Indices past the last register read back as 0.
    always_comb begin
        rdata = '0;
        for (int s = 0; s < NUM_SEMS; s++) begin
            if (addr == ADDR_W'(s)) begin
                rdata = owners[s*ID_W +: ID_W];
            end
        end
    end

endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
    parameter int NUM_MASTERS = 3,
    parameter int NUM_SEMS    = 16,
    parameter int ID_W        = 8,
    parameter int ADDR_W      = (NUM_SEMS > 1) ? $clog2(NUM_SEMS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_MASTERS-1:0]        bus_we,
    input  logic [NUM_MASTERS*ADDR_W-1:0] bus_addr,
    input  logic [NUM_MASTERS*ID_W-1:0]   bus_wdata,
    output logic [NUM_MASTERS*ID_W-1:0]   bus_rdata
);

    logic [NUM_SEMS*ID_W-1:0] owners;

    for (genvar s = 0; s < NUM_SEMS; s++) begin : g_sem
        logic [NUM_MASTERS-1:0] grant;
        logic                   wr_valid;
        logic [ID_W-1:0]        wr_data;
        logic [ID_W-1:0]        owner;

        sem_arbiter #(
            .NUM_MASTERS(NUM_MASTERS),
            .ADDR_W     (ADDR_W),
            .ID_W       (ID_W),
            .SEM_IDX    (s)
        ) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (bus_we),
            .addr    (bus_addr),
            .wdata   (bus_wdata),
            .grant   (grant),
            .wr_valid(wr_valid),
            .wr_data (wr_data)
        );

        sem_cell #(
            .ID_W(ID_W)
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_valid(wr_valid),
            .wr_data (wr_data),
            .owner   (owner)
        );

        assign owners[s*ID_W +: ID_W] = owner;
    end

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_port
        sem_read_port #(
            .NUM_SEMS(NUM_SEMS),
            .ADDR_W  (ADDR_W),
            .ID_W    (ID_W)
        ) u_rd (
            .addr  (bus_addr[m*ADDR_W +: ADDR_W]),
            .owners(owners),
            .rdata (bus_rdata[m*ID_W +: ID_W])
        );
    end

endmodule

// File: tb/sim_sem_bank.sv
module sim_sem_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NM   = 3;
    localparam int NS   = 16;
    localparam int IDW  = 8;
    localparam int AW   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NM-1:0]     bus_we = '0;
    logic [NM*AW-1:0]  bus_addr = '0;
    logic [NM*IDW-1:0] bus_wdata = '0;
    logic [NM*IDW-1:0] bus_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [IDW-1:0] model [NS];

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_bank #(.NUM_MASTERS(NM), .NUM_SEMS(NS), .ID_W(IDW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Expected next content of register r, from R2/R3/R5/R7/R8
    function automatic logic [IDW-1:0] next_val(int r, logic [IDW-1:0] cur);
        for (int m = 0; m < NM; m++) begin
            if (bus_we[m] && int'(bus_addr[m*AW +: AW]) == r) begin
                logic [IDW-1:0] d = bus_wdata[m*IDW +: IDW];
                if (cur == '0 || d == '0) return d;
                return cur;
            end
        end
        return cur;
    endfunction

    task automatic set_port(int m, bit we, int a, logic [IDW-1:0] d);
        bus_we[m]                = we;
        bus_addr[m*AW +: AW]     = AW'(a);
        bus_wdata[m*IDW +: IDW]  = d;
    endtask

    // Check reads (before the edge), then advance one cycle with the model.
    task automatic step(string tag);
        logic [IDW-1:0] nxt [NS];
        #1;
        for (int m = 0; m < NM; m++) begin
            logic [IDW-1:0] exp_v = model[int'(bus_addr[m*AW +: AW])];
            logic [IDW-1:0] got   = bus_rdata[m*IDW +: IDW];
            n_checks++;
            if (got !== exp_v) begin
                n_fails++;
                $display("FAIL %s master %0d reg %0d: got %02h expected %02h",
                         tag, m, bus_addr[m*AW +: AW], got, exp_v);
            end
        end
        for (int r = 0; r < NS; r++) nxt[r] = next_val(r, model[r]);
        @(posedge clk);
        for (int r = 0; r < NS; r++) model[r] = nxt[r];
        @(negedge clk);
        bus_we = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bus_we = '0;
        for (int r = 0; r < NS; r++) model[r] = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic read_all(string tag);
        for (int r = 0; r < NS; r += NM) begin
            for (int m = 0; m < NM; m++) set_port(m, 1'b0, (r + m) % NS, '0);
            step(tag);
        end
    endtask

    task automatic read_reg(int a, string tag);
        for (int m = 0; m < NM; m++) set_port(m, 1'b0, a, '0);
        step(tag);
    endtask

    initial begin
        void'($urandom(32'd20210806));
        @(negedge clk);
        do_reset();

        // R1: every register zero after reset
        read_all("R1");

        // R2/R6: master 1 takes register 3, all read it back
        set_port(1, 1'b1, 3, 8'h21);
        step("R2");
        read_reg(3, "R6");

        // R3: master 2 tries to take held register 3, dropped
        set_port(2, 1'b1, 3, 8'h33);
        step("R3");
        read_reg(3, "R3");

        // R5: master 2 clears register 3 although it is not the owner
        set_port(2, 1'b1, 3, 8'h00);
        step("R5");
        read_reg(3, "R5");

        // R7: three-way take on register 7, master 0 wins
        set_port(0, 1'b1, 7, 8'h10);
        set_port(1, 1'b1, 7, 8'h20);
        set_port(2, 1'b1, 7, 8'h30);
        step("R7");
        read_reg(7, "R7");

        // R8: zero write from master 0 blocks master 1 take on free register 9
        set_port(0, 1'b1, 9, 8'h00);
        set_port(1, 1'b1, 9, 8'h55);
        step("R8");
        read_reg(9, "R8");

        // R9: independent takes in one cycle
        set_port(0, 1'b1, 0, 8'hA1);
        set_port(1, 1'b1, 15, 8'hB2);
        set_port(2, 1'b1, 12, 8'hC3);
        step("R9");
        for (int m = 0; m < NM; m++) set_port(m, 1'b0, (m == 0) ? 0 : (m == 1) ? 15 : 12, '0);
        step("R10");

        // R4: random traffic, contention-heavy then spread
        for (int i = 0; i < 3000; i++) begin
            for (int m = 0; m < NM; m++) begin
                int a = (i < 1500) ? int'($urandom % 3) : int'($urandom % NS);
                logic [IDW-1:0] d = ($urandom % 3 == 0) ? 8'h00 : IDW'(m + 1 + 16 * ($urandom % 4));
                set_port(m, ($urandom % 2) == 1, a, d);
            end
            step("R4");
        end

        // R1: reset mid-run clears everything
        do_reset();
        read_all("R1");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule